// File: doc/BRIEF.md
# Serial EEPROM Instruction Front End

This block is the slave side of a three-wire serial memory port with 16-bit words. A bus master selects the device, clocks a start bit, a two-bit opcode and an address field into it, and then either streams words back out or hands a write-type command on to a separate write sequencer. All three bus inputs (select, serial clock, data in) are oversampled by a fast system clock through two-flop synchronizers. Serial clock edges are found from the synchronized copy, so every piece of logic runs in the system clock domain.

A read loads the addressed word from a register array of 2^AW words. Before the first word it sends one zero bit. It then shifts the word out most significant bit first, with each bit changing on a serial clock rise. While select stays high, the address steps on and the next word follows with no gap, wrapping from the top word to word 0. A write-enable latch is cleared by reset, set by the enable instruction (opcode 00, address prefix 11) and cleared by the disable instruction (opcode 00, address prefix 00). Every other non-read instruction is forwarded as a one-cycle request, and only while the latch is set. The write sequencer fills the array through a plain write port.

The controller has six states. In IDLE, select is low. START waits for the start bit. OPC collects two opcode bits. ADDR collects AW address bits. READ streams data. HOLD ignores the bus until select drops. Transitions: IDLE→START when select is seen high while the serial clock is low. IDLE→HOLD when select is seen high while the clock is high. START→OPC on a clock rise with data-in 1. OPC→ADDR after the second opcode bit. ADDR→READ after the last address bit of opcode 10. ADDR→HOLD after the last address bit of any other opcode. Any state→IDLE when select is low.

Top module: `mw_fe`

## Requirements
- R1: After reset the data-out enable is low, the write-enable latch reads 0 and no request is issued.
- R2: If select rises while the serial clock is high, the whole selection is ignored: no data-out enable and no request until select goes low again.
- R3: Zero bits sampled before the first 1 are skipped; the first 1 sampled on a clock rise is the start bit.
- R4: Opcode 10 is a read. On the clock rise that samples the last address bit, data-out becomes enabled and carries a 0 dummy bit. The next 16 rises present the addressed word, most significant bit first.
- R5: While select stays high, the word at the next address follows directly after bit 0, with no dummy bit.
- R6: Sequential reading wraps from address 2^AW-1 to address 0.
- R7: Opcode 00 with address prefix 11 sets the write-enable latch, and prefix 00 clears it. A read works with the latch either set or clear.
- R8: Any other instruction pulses req_valid for exactly one system clock, carrying its opcode and address, and only when the latch is set; otherwise it is dropped.
- R9: Dropping select abandons any partial instruction or read; data-out enable falls within one system clock of the synchronized select going low.
- R10: A word written through the array write port is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select from the bus master, active high |
| sk_i | input | 1 | Serial clock from the bus master |
| di_i | input | 1 | Serial data in |
| arr_we | input | 1 | Array write strobe from the write sequencer |
| arr_waddr | input | AW | Array write address |
| arr_wdata | input | 16 | Array write data |
| do_o | output | 1 | Serial data out (0 when not enabled) |
| do_oe | output | 1 | Data-out drive enable |
| wr_allow | output | 1 | Write-enable latch state |
| req_valid | output | 1 | One-cycle write-type request strobe |
| req_op | output | 2 | Opcode of the request |
| req_addr | output | AW | Address field of the request |

## Verification
The hardest states to reach are the word boundaries inside one long selection. These are the hand-off from bit 0 of one word to bit 15 of the next with no dummy bit, and the wrap from the top address back to 0. The stimulus table therefore includes multi-word reads that start just below the top of the array and hold select across several words. The ignored-select case needs select to rise while the serial clock is already high, so a directed test parks the clock high before selecting. The abort case drops select partway through a word and then checks that a fresh read still starts cleanly.

// File: rtl/mw_fe_pkg.sv
package mw_fe_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_OPC,
        ST_ADDR,
        ST_READ,
        ST_HOLD
    } fe_state_t;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] PFX_WEN  = 2'b11;
    localparam logic [1:0] PFX_WDS  = 2'b00;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/mw_fe.sv
module mw_fe
    import mw_fe_pkg::*;
#(
    parameter int AW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sk_i,
    input  logic              di_i,
    input  logic              arr_we,
    input  logic [AW-1:0]     arr_waddr,
    input  logic [WORD_W-1:0] arr_wdata,
    output logic              do_o,
    output logic              do_oe,
    output logic              wr_allow,
    output logic              req_valid,
    output logic [1:0]        req_op,
    output logic [AW-1:0]     req_addr
);

    localparam int CW = (AW > WORD_W) ? $clog2(AW) : $clog2(WORD_W);
    localparam logic [CW-1:0] ADDR_LAST = CW'(AW - 1);
    localparam logic [CW-1:0] BIT_LAST  = CW'(WORD_W - 1);

    logic cs_s, sk_s, di_s, sk_q, sk_rise;

    mw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_i, sk_i, di_i}),
        .q     ({cs_s, sk_s, di_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk_s;
    end
    assign sk_rise = sk_s & ~sk_q;

    fe_state_t        state, nxt;
    logic [CW-1:0]    cnt;
    logic [1:0]       opc;
    logic [AW-1:0]    sh_addr, addr_full, rd_addr;
    logic [WORD_W-1:0] word;
    logic             dout;

    assign addr_full = {sh_addr[AW-2:0], di_s};

    mw_word_array #(.AW(AW), .DW(WORD_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (rd_addr),
        .rdata (word)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (!cs_s) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = sk_s ? ST_HOLD : ST_START;
                ST_START: if (sk_rise && di_s) nxt = ST_OPC;
                ST_OPC:   if (sk_rise && cnt == CW'(1)) nxt = ST_ADDR;
                ST_ADDR:  if (sk_rise && cnt == ADDR_LAST)
                              nxt = (opc == OP_READ) ? ST_READ : ST_HOLD;
                ST_READ:  nxt = ST_READ;
                ST_HOLD:  nxt = ST_HOLD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            opc       <= '0;
            sh_addr   <= '0;
            rd_addr   <= '0;
            dout      <= 1'b0;
            wr_allow  <= 1'b0;
            req_valid <= 1'b0;
            req_op    <= '0;
            req_addr  <= '0;
        end else begin
            req_valid <= 1'b0;
            unique case (state)
                ST_OPC: begin
                    if (sk_rise) begin
                        opc <= {opc[0], di_s};
                        cnt <= (cnt == CW'(1)) ? '0 : cnt + CW'(1);
                    end
                end
                ST_ADDR: begin
                    if (sk_rise) begin
                        sh_addr <= addr_full;
                        if (cnt == ADDR_LAST) begin
                            cnt <= '0;
                            if (opc == OP_READ) begin
                                rd_addr <= addr_full;
                                dout    <= 1'b0;
                            end else if (opc == OP_EXT &&
                                         addr_full[AW-1 -: 2] == PFX_WEN) begin
                                wr_allow <= 1'b1;
                            end else if (opc == OP_EXT &&
                                         addr_full[AW-1 -: 2] == PFX_WDS) begin
                                wr_allow <= 1'b0;
                            end else if (wr_allow) begin
                                req_valid <= 1'b1;
                                req_op    <= opc;
                                req_addr  <= addr_full;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                ST_READ: begin
                    if (sk_rise) begin
                        dout <= word[BIT_LAST - cnt];
                        if (cnt == BIT_LAST) begin
                            cnt     <= '0;
                            rd_addr <= rd_addr + AW'(1);
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                ST_IDLE, ST_START, ST_HOLD: cnt <= '0;
            endcase
        end
    end

    assign do_oe = (state == ST_READ);
    assign do_o  = do_oe & dout;

    // R9: losing select removes the data-out drive on the next cycle
    a_r9_oe_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !do_oe);

    // R4: the first bit presented after enable is the dummy zero
    a_r4_dummy_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(do_oe) |-> !do_o);

    // R8: a request is only issued while the latch is set
    a_r8_req_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> wr_allow);

    // R8: requests last one cycle
    a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R7: the latch changes only on a serial clock rise
    a_r7_latch_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !sk_rise |=> $stable(wr_allow));

    // R2: a selection that began with the clock high never drives data
    a_r2_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> !do_oe);

endmodule

// File: tb/mw_fe_tb.sv
module mw_fe_tb;

    localparam int AW   = 8;
    localparam int HALF = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic arr_we = 1'b0;
    logic [AW-1:0] arr_waddr = '0;
    logic [15:0]   arr_wdata = '0;
    logic do_o, do_oe, wr_allow, req_valid;
    logic [1:0] req_op;
    logic [AW-1:0] req_addr;

    mw_fe #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
        .do_o(do_o), .do_oe(do_oe), .wr_allow(wr_allow),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [15:0] shadow [256];

    int req_cnt = 0;
    logic [1:0] last_op;
    logic [AW-1:0] last_addr;
    always @(posedge clk) begin
        if (req_valid) begin
            req_cnt   <= req_cnt + 1;
            last_op   <= req_op;
            last_addr <= req_addr;
        end
    end

    // {start address, word count}
    localparam logic [15:0] VEC [0:5] = '{
        16'h0001, 16'h7E02, 16'hFF03, 16'hA501, 16'h3C04, 16'hFE04
    };

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic d, output logic q, output logic oe);
        di = d;
        repeat (HALF) @(negedge clk);
        sk = 1'b1;
        repeat (HALF) @(negedge clk);
        q  = do_o;
        oe = do_oe;
        sk = 1'b0;
    endtask

    task automatic select_on();
        sk = 1'b0;
        cs = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic select_off();
        cs = 1'b0;
        sk = 1'b0;
        repeat (2 * HALF) @(negedge clk);
    endtask

    // start bit, opcode, address; returns sample of the last address rise
    task automatic header(input int zeros, input logic [1:0] op,
                          input logic [AW-1:0] a, output logic q, output logic oe);
        for (int i = 0; i < zeros; i++) pulse(1'b0, q, oe);
        pulse(1'b1, q, oe);
        pulse(op[1], q, oe);
        pulse(op[0], q, oe);
        for (int i = AW - 1; i >= 0; i--) pulse(a[i], q, oe);
    endtask

    task automatic read_words(input int zeros, input logic [AW-1:0] a,
                              input int n, input string tag);
        logic q, oe;
        logic [15:0] w;
        logic [AW-1:0] ea;
        select_on();
        header(zeros, 2'b10, a, q, oe);
        chk(oe === 1'b1 && q === 1'b0, {tag, " R4 dummy"}, {14'd0, oe, q}, 16'h0002);
        for (int k = 0; k < n; k++) begin
            w = '0;
            for (int b = 0; b < 16; b++) begin
                pulse(1'b0, q, oe);
                w = {w[14:0], q};
            end
            ea = a + AW'(k);
            chk(w === shadow[ea], {tag, (k == 0) ? " R4 word" : " R5 R6 next word"},
                w, shadow[ea]);
        end
        select_off();
    endtask

    task automatic command(input logic [1:0] op, input logic [AW-1:0] a);
        logic q, oe;
        select_on();
        header(0, op, a, q, oe);
        select_off();
    endtask

    task automatic arr_write(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        arr_we = 1'b1; arr_waddr = a; arr_wdata = d;
        @(negedge clk);
        arr_we = 1'b0;
        shadow[a] = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic q, oe;
        int  base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        chk(do_oe === 1'b0, "R1 oe", {15'd0, do_oe}, 16'd0);
        chk(wr_allow === 1'b0, "R1 latch", {15'd0, wr_allow}, 16'd0);
        chk(req_cnt == 0, "R1 no request", 16'(req_cnt), 16'd0);

        // R10: load array through write port
        for (int a = 0; a < 256; a++)
            arr_write(AW'(a), {8'(a) ^ 8'h5A, ~8'(a)});

        // table: reads with latch clear (R4 R5 R6 R7)
        foreach (VEC[i]) begin
            read_words(0, VEC[i][15:8], int'(VEC[i][7:0]), "table");
        end

        // R3: leading zeros before the start bit
        read_words(3, 8'h10, 1, "R3 zeros");

        // R10: overwrite and read back
        arr_write(8'h22, 16'hBEEF);
        read_words(0, 8'h22, 1, "R10 rewrite");

        // R8: request dropped while latch clear
        base = req_cnt;
        command(2'b01, 8'h35);
        chk(req_cnt == base, "R8 dropped when clear", 16'(req_cnt - base), 16'd0);

        // R7: enable
        command(2'b00, 8'hC0);
        chk(wr_allow === 1'b1, "R7 set", {15'd0, wr_allow}, 16'd1);

        // R8: request forwarded
        base = req_cnt;
        command(2'b01, 8'h35);
        chk(req_cnt == base + 1, "R8 forwarded", 16'(req_cnt - base), 16'd1);
        chk(last_op === 2'b01 && last_addr === 8'h35, "R8 fields",
            {6'd0, last_op, last_addr}, 16'h0135);

        // R7: read with latch set
        read_words(0, 8'h80, 2, "R7 read latch set");

        // R7: disable
        command(2'b00, 8'h00);
        chk(wr_allow === 1'b0, "R7 cleared", {15'd0, wr_allow}, 16'd0);

        // R2: select rises while clock high
        sk = 1'b1;
        repeat (HALF) @(negedge clk);
        cs = 1'b1;
        repeat (HALF) @(negedge clk);
        sk = 1'b0;
        repeat (HALF) @(negedge clk);
        header(0, 2'b10, 8'h05, q, oe);
        chk(oe === 1'b0, "R2 ignored", {15'd0, oe}, 16'd0);
        select_off();

        // R9: abort mid-word
        select_on();
        header(0, 2'b10, 8'h40, q, oe);
        for (int b = 0; b < 5; b++) pulse(1'b0, q, oe);
        cs = 1'b0;
        repeat (6) @(negedge clk);
        chk(do_oe === 1'b0, "R9 abort", {15'd0, do_oe}, 16'd0);
        select_off();
        read_words(0, 8'h41, 1, "R9 after abort");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule